// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block arbitrates eight interrupt request lines for a CPU. It keeps a pending-request register, a mask register and an in-service register, and it raises one interrupt output whenever the best unmasked pending request outranks everything already in service. Priority is not fixed to line numbers. A three-bit rotation offset decides which line currently sits at the top, and several commands move that offset.

Software drives the block through a byte-wide port with one address bit. Address 0 takes the start-of-initialisation word, control words and end-of-interrupt or rotation commands. Address 1 takes the initialisation data words and afterwards the mask. The CPU acknowledges with a one-cycle `inta_i` pulse. In that same cycle `vec_o` shows the programmed vector base combined with the winning line, and the in-service bookkeeping updates on the closing clock edge. Requests arrive as one-cycle pulses on `req_i`. Each pulse sets the matching pending bit. Any edge or level conditioning happens upstream.

Top module: `pic_core`

## Requirements
- R1: Priority rank k (k = 0 is highest) belongs to line (k + offset) mod 8. A poll read of several pending, unmasked lines with an empty in-service register returns them one by one in that order.
- R2: `irq_o` is 1 only when an unmasked pending line exists and its rank is strictly better than the best in-service line. A pending line whose mask bit is 1 never raises `irq_o`.
- R3: An address-0 write with bit 4 = 1 begins initialisation. It clears the pending, mask and in-service registers, the offset, the vector base and all modes, and drops `irq_o` from the next cycle. Bit 0 of that word says whether a mode word follows. The next address-1 writes are, in order: the vector base (bits 7:3 kept), a cascade word that is ignored, and, only if announced, the mode word (bit 1 = automatic end-of-interrupt).
- R4: Once initialisation has finished, an address-1 write loads the mask register. An address-1 read returns the mask at all times.
- R5: An address-0 write with bit 4 = 0 and bit 3 = 1 is a control word. Bit 1 = 1 loads read-select from bit 0, so that address-0 reads return in-service (1) or pending (0). Bit 2 = 1 arms a poll. Bit 6 = 1 loads special-mask mode from bit 5.
- R6: Command 1 (bits 7:5 = 001) clears the best-ranked in-service bit. Command 5 does the same and then sets the offset to that line + 1.
- R7: Command 3 clears in-service bit bits[2:0]. Command 7 does the same and sets the offset to bits[2:0] + 1. Command 6 sets the offset to bits[2:0] + 1. Commands 0 and 4 load rotate-on-auto-EOI from bit 7.
- R8: An `inta_i` pulse while `irq_o` = 1 outputs `vec_o` = base | line. It clears that line's pending bit and, without automatic end-of-interrupt, sets its in-service bit.
- R9: With automatic end-of-interrupt, an acknowledge leaves the in-service register unchanged. If rotate-on-auto-EOI is 1, the offset becomes line + 1. Otherwise the offset is kept.
- R10: When a poll is armed, the next read returns the winning line in bits 2:0 (or 7 if none), clears that line's pending and in-service bits, and disarms the poll.
- R11: An acknowledge while `irq_o` = 0 outputs base | 7 and changes no register.
- R12: In special-mask mode, in-service lines whose mask bit is 1 do not block lower-ranked requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Request pulses, one bit per line |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe (needed for poll side effects) |
| addr_i | input | 1 | Port address bit |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte |
| inta_i | input | 1 | One-cycle interrupt acknowledge |
| vec_o | output | 8 | Vector for the acknowledge in progress |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bench uses the default eight-line build. That size lets it sweep every non-zero request pattern under each of the eight rotation offsets. For each combination it drains the pending lines through successive polls and compares every returned line with a rank computed arithmetically from the offset. Directed sequences then exercise nested acknowledges, every command variant, both initialisation lengths, automatic end-of-interrupt with and without rotation, spurious acknowledges and special-mask mode.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int unsigned PIC_LINES = 8;
    localparam int unsigned PIC_IDX_W = $clog2(PIC_LINES);
    localparam int unsigned PIC_DW    = 8;

    typedef enum logic [1:0] {
        INIT_RUN  = 2'd0,
        INIT_BASE = 2'd1,
        INIT_CASC = 2'd2,
        INIT_MODE = 2'd3
    } init_e;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_INIT,
        OP_CTRL,
        OP_ROT_AEOI,
        OP_NS_EOI,
        OP_NS_EOI_ROT,
        OP_SP_EOI,
        OP_SET_PRIO,
        OP_SP_EOI_ROT,
        OP_DATA
    } op_e;

    typedef struct packed {
        logic [PIC_LINES-1:0] irr;
        logic [PIC_LINES-1:0] imr;
        logic [PIC_LINES-1:0] isr;
        logic [PIC_IDX_W-1:0] offs;
        logic [PIC_DW-1:0]    base;
        logic                 rsel;
        logic                 poll;
        logic                 smask;
        logic                 aeoi;
        logic                 rot_aeoi;
        logic                 need4;
        init_e                init;
    } pic_state_t;

endpackage

// File: rtl/pic_prio_find.sv
module pic_prio_find #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  bits_i,
    input  logic [IW-1:0] offs_i,
    output logic [IW:0]   rank_o
);
    // rank N means "nothing set"; rank k refers to line (k + offs) mod N
    always_comb begin
        rank_o = (IW+1)'(N);
        for (int k = N - 1; k >= 0; k--) begin
            if (bits_i[IW'(k) + offs_i]) begin
                rank_o = (IW+1)'(k);
            end
        end
    end
endmodule

// File: rtl/pic_cmd_dec.sv
module pic_cmd_dec
    import pic_pkg::*;
(
    input  logic              wr_en_i,
    input  logic              addr_i,
    input  logic [PIC_DW-1:0] wdata_i,
    output op_e               op_o
);
    always_comb begin
        op_o = OP_NONE;
        if (wr_en_i) begin
            if (addr_i) begin
                op_o = OP_DATA;
            end else if (wdata_i[4]) begin
                op_o = OP_INIT;
            end else if (wdata_i[3]) begin
                op_o = OP_CTRL;
            end else begin
                unique case (wdata_i[7:5])
                    3'd0, 3'd4: op_o = OP_ROT_AEOI;
                    3'd1:       op_o = OP_NS_EOI;
                    3'd5:       op_o = OP_NS_EOI_ROT;
                    3'd3:       op_o = OP_SP_EOI;
                    3'd6:       op_o = OP_SET_PRIO;
                    3'd7:       op_o = OP_SP_EOI_ROT;
                    default:    op_o = OP_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [PIC_LINES-1:0] req_i,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic                 addr_i,
    input  logic [PIC_DW-1:0]    wdata_i,
    output logic [PIC_DW-1:0]    rdata_o,
    input  logic                 inta_i,
    output logic [PIC_DW-1:0]    vec_o,
    output logic                 irq_o
);
    localparam int unsigned N       = PIC_LINES;
    localparam int unsigned IW      = PIC_IDX_W;
    localparam int unsigned N_ENC   = 3;
    localparam int unsigned ENC_REQ = 0;
    localparam int unsigned ENC_CUR = 1;
    localparam int unsigned ENC_ISR = 2;
    localparam logic [PIC_DW-1:0] BASE_KEEP = ~PIC_DW'(N - 1);
    localparam logic [IW-1:0]     SPURIOUS  = IW'(N - 1);

    pic_state_t s_d, s_q;
    op_e        op;

    logic [N-1:0]  enc_bits [N_ENC];
    logic [IW:0]   enc_rank [N_ENC];
    logic [IW-1:0] req_line;
    logic [IW-1:0] isr_line;
    logic          isr_any;
    logic          want;
    logic [IW-1:0] out_line;
    logic [IW-1:0] sel_line;

    // inputs of the three priority searches
    always_comb begin
        enc_bits[ENC_REQ] = s_q.irr & ~s_q.imr;
        enc_bits[ENC_CUR] = s_q.smask ? (s_q.isr & ~s_q.imr) : s_q.isr;
        enc_bits[ENC_ISR] = s_q.isr;
    end

    for (genvar g = 0; g < N_ENC; g++) begin : g_enc
        pic_prio_find #(.N(N), .IW(IW)) u_find (
            .bits_i (enc_bits[g]),
            .offs_i (s_q.offs),
            .rank_o (enc_rank[g])
        );
    end

    pic_cmd_dec u_dec (
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .op_o    (op)
    );

    always_comb begin
        req_line = enc_rank[ENC_REQ][IW-1:0] + s_q.offs;
        isr_line = enc_rank[ENC_ISR][IW-1:0] + s_q.offs;
        isr_any  = !enc_rank[ENC_ISR][IW];
        want     = enc_rank[ENC_REQ] < enc_rank[ENC_CUR];
        out_line = want ? req_line : SPURIOUS;
        sel_line = wdata_i[IW-1:0];
    end

    assign irq_o = want;
    assign vec_o = s_q.base | PIC_DW'(out_line);

    always_comb begin
        if (s_q.poll) begin
            rdata_o = PIC_DW'(out_line);
        end else if (addr_i) begin
            rdata_o = s_q.imr;
        end else if (s_q.rsel) begin
            rdata_o = s_q.isr;
        end else begin
            rdata_o = s_q.irr;
        end
    end

    // next-state computation
    always_comb begin
        s_d = s_q;

        // acknowledge
        if (inta_i && want) begin
            s_d.irr[req_line] = 1'b0;
            if (s_q.aeoi) begin
                if (s_q.rot_aeoi) begin
                    s_d.offs = req_line + 1'b1;
                end
            end else begin
                s_d.isr[req_line] = 1'b1;
            end
        end

        // polled read
        if (rd_en_i && s_q.poll) begin
            s_d.poll = 1'b0;
            if (want) begin
                s_d.irr[req_line] = 1'b0;
                s_d.isr[req_line] = 1'b0;
            end
        end

        s_d.irr = s_d.irr | req_i;

        unique case (op)
            OP_INIT: begin
                s_d       = '0;
                s_d.init  = INIT_BASE;
                s_d.need4 = wdata_i[0];
            end
            OP_CTRL: begin
                if (wdata_i[2]) s_d.poll  = 1'b1;
                if (wdata_i[1]) s_d.rsel  = wdata_i[0];
                if (wdata_i[6]) s_d.smask = wdata_i[5];
            end
            OP_ROT_AEOI: s_d.rot_aeoi = wdata_i[7];
            OP_NS_EOI: begin
                if (isr_any) s_d.isr[isr_line] = 1'b0;
            end
            OP_NS_EOI_ROT: begin
                if (isr_any) begin
                    s_d.isr[isr_line] = 1'b0;
                    s_d.offs          = isr_line + 1'b1;
                end
            end
            OP_SP_EOI: s_d.isr[sel_line] = 1'b0;
            OP_SET_PRIO: s_d.offs = sel_line + 1'b1;
            OP_SP_EOI_ROT: begin
                s_d.isr[sel_line] = 1'b0;
                s_d.offs          = sel_line + 1'b1;
            end
            OP_DATA: begin
                unique case (s_q.init)
                    INIT_RUN:  s_d.imr = wdata_i;
                    INIT_BASE: begin
                        s_d.base = wdata_i & BASE_KEEP;
                        s_d.init = INIT_CASC;
                    end
                    INIT_CASC: s_d.init = s_q.need4 ? INIT_MODE : INIT_RUN;
                    INIT_MODE: begin
                        s_d.aeoi = wdata_i[1];
                        s_d.init = INIT_RUN;
                    end
                    default:   s_d.init = INIT_RUN;
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk
    import pic_pkg::*;
(
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 wr_en_i,
    input logic                 rd_en_i,
    input logic                 addr_i,
    input logic [PIC_DW-1:0]    wdata_i,
    input logic                 inta_i,
    input logic [PIC_DW-1:0]    vec_o,
    input logic                 irq_o,
    input logic [PIC_LINES-1:0] irr_q,
    input logic [PIC_LINES-1:0] imr_q,
    input logic [PIC_LINES-1:0] isr_q,
    input logic                 poll_q,
    input logic                 aeoi_q
);
    AST_INIT_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !addr_i && wdata_i[4]) |=> !irq_o); // R3

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ((irr_q & ~imr_q) != '0)); // R2

    AST_POLL_ONESHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && poll_q && !wr_en_i) |=> !poll_q); // R10

    AST_SPURIOUS_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inta_i && !irq_o) |-> (vec_o[2:0] == 3'd7)); // R11

    AST_AEOI_ISR_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inta_i && irq_o && aeoi_q && !wr_en_i && !rd_en_i) |=> $stable(isr_q)); // R9

endmodule

bind pic_core pic_core_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .inta_i  (inta_i),
    .vec_o   (vec_o),
    .irq_o   (irq_o),
    .irr_q   (s_q.irr),
    .imr_q   (s_q.imr),
    .isr_q   (s_q.isr),
    .poll_q  (s_q.poll),
    .aeoi_q  (s_q.aeoi)
);

// File: tb/tb_pic_core.sv
module tb_pic_core;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [7:0] req_i = '0;
    logic       wr_en_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic       addr_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       inta_i = 1'b0;
    logic [7:0] vec_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk_i = ~clk_i;

    pic_core dut (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (req_i),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .inta_i  (inta_i),
        .vec_o   (vec_o),
        .irq_o   (irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk_i);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk_i);
        wr_en_i = 1'b0; addr_i = 1'b0; wdata_i = '0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk_i);
        rd_en_i = 1'b1; addr_i = a;
        #1 d = rdata_o;
        @(negedge clk_i);
        rd_en_i = 1'b0; addr_i = 1'b0;
    endtask

    task automatic ack(output logic [7:0] v);
        @(negedge clk_i);
        inta_i = 1'b1;
        #1 v = vec_o;
        @(negedge clk_i);
        inta_i = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] r);
        @(negedge clk_i);
        req_i = r;
        @(negedge clk_i);
        req_i = '0;
    endtask

    task automatic poll(output logic [7:0] d);
        wr(1'b0, 8'h0C);
        rd(1'b0, d);
    endtask

    function automatic int best(input logic [7:0] p, input int off);
        for (int k = 0; k < 8; k++) begin
            if (p[(k + off) % 8]) return (k + off) % 8;
        end
        return 7;
    endfunction

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] p;
        int e;

        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk("R2 reset irq", irq_o, 0);
        rd(1'b0, d); chk("R5 reset pending read", d, 0);
        rd(1'b1, d); chk("R4 reset mask read", d, 0);

        // init with mode word, base 0x48, no auto EOI
        wr(1'b0, 8'h11); wr(1'b1, 8'h4D); wr(1'b1, 8'h00); wr(1'b1, 8'h00);
        wr(1'b1, 8'h00);
        rd(1'b1, d); chk("R4 mask after init", d, 0);

        // R1 sweep: every pattern, every offset, drained by polls
        for (int off = 0; off < 8; off++) begin
            wr(1'b0, 8'hC0 | 8'((off + 7) % 8));
            for (int pat = 1; pat < 256; pat++) begin
                pulse(8'(pat));
                chk("R2 irq with pending", irq_o, 1);
                if (off == 0) begin
                    rd(1'b0, d); chk("R5 pending read", d, pat);
                end
                p = 8'(pat);
                while (p != 0) begin
                    poll(d);
                    e = best(p, off);
                    chk("R1 R10 poll order", d, e);
                    p[e] = 1'b0;
                end
                chk("R10 irq after drain", irq_o, 0);
            end
        end

        wr(1'b0, 8'hC7); // offset 0
        // nested acknowledges
        pulse(8'h20); chk("R2 irq line5", irq_o, 1);
        ack(d); chk("R8 vector line5", d, 8'h4D);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R8 R5 in-service read", d, 8'h20);
        chk("R2 irq after ack", irq_o, 0);
        pulse(8'h40); chk("R2 lower rank blocked", irq_o, 0);
        pulse(8'h08); chk("R2 higher rank raises", irq_o, 1);
        ack(d); chk("R8 vector line3", d, 8'h4B);
        rd(1'b0, d); chk("R8 nested in-service", d, 8'h28);
        wr(1'b0, 8'h20);
        rd(1'b0, d); chk("R6 non-specific EOI", d, 8'h20);
        chk("R2 still blocked", irq_o, 0);
        wr(1'b0, 8'h65);
        rd(1'b0, d); chk("R7 specific EOI", d, 8'h00);
        chk("R7 irq after specific EOI", irq_o, 1);
        ack(d); chk("R8 vector line6", d, 8'h4E);

        // rotate on non-specific EOI: line 6 -> offset 7
        wr(1'b0, 8'hA0);
        rd(1'b0, d); chk("R6 rotate EOI clears", d, 8'h00);
        pulse(8'h81);
        poll(d); chk("R6 rotated first", d, 7);
        poll(d); chk("R6 rotated second", d, 0);
        chk("R10 irq after polls", irq_o, 0);

        // specific EOI with rotate: offset 3
        wr(1'b0, 8'hE2);
        pulse(8'h0A);
        poll(d); chk("R7 rotate specific first", d, 3);
        poll(d); chk("R7 rotate specific second", d, 1);
        wr(1'b0, 8'hC7);

        // mask
        wr(1'b1, 8'h08);
        rd(1'b1, d); chk("R4 mask read", d, 8'h08);
        pulse(8'h08); chk("R2 masked line ignored", irq_o, 0);
        wr(1'b1, 8'h00); chk("R4 unmask raises", irq_o, 1);
        ack(d); chk("R8 vector after unmask", d, 8'h4B);
        wr(1'b0, 8'h20);
        rd(1'b0, d); chk("R6 EOI empties", d, 8'h00);

        // spurious acknowledge
        ack(d); chk("R11 spurious vector", d, 8'h4F);
        rd(1'b0, d); chk("R11 no in-service change", d, 8'h00);
        wr(1'b0, 8'h0A);
        rd(1'b0, d); chk("R11 no pending change", d, 8'h00);

        // special mask
        pulse(8'h20); ack(d);
        pulse(8'h40); chk("R12 blocked before special mask", irq_o, 0);
        wr(1'b1, 8'h20); wr(1'b0, 8'h68);
        chk("R12 special mask unblocks", irq_o, 1);
        wr(1'b0, 8'h48);
        chk("R12 special mask off", irq_o, 0);
        wr(1'b1, 8'h00); wr(1'b0, 8'h65);
        ack(d); chk("R12 vector line6", d, 8'h4E);
        wr(1'b0, 8'h20);

        // re-init with auto EOI and base 0x20
        wr(1'b1, 8'h55);
        pulse(8'h02);
        wr(1'b0, 8'h11);
        chk("R3 irq dropped", irq_o, 0);
        rd(1'b1, d); chk("R3 mask cleared", d, 0);
        wr(1'b1, 8'h27); wr(1'b1, 8'h00); wr(1'b1, 8'h02);
        rd(1'b0, d); chk("R3 pending cleared", d, 0);
        wr(1'b0, 8'h80);
        pulse(8'h10);
        ack(d); chk("R3 R9 base and vector", d, 8'h24);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R9 no in-service", d, 8'h00);
        chk("R9 irq low", irq_o, 0);
        pulse(8'h30);
        poll(d); chk("R9 rotated on ack", d, 5);
        poll(d); chk("R9 rotated second", d, 4);
        wr(1'b0, 8'h00);
        pulse(8'h40);
        ack(d); chk("R9 vector line6", d, 8'h26);
        pulse(8'h21);
        poll(d); chk("R9 no rotate kept offset", d, 5);
        poll(d); chk("R9 no rotate second", d, 0);

        // init without mode word
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h80); wr(1'b1, 8'h00); wr(1'b1, 8'h33);
        rd(1'b1, d); chk("R3 R4 three-word init mask", d, 8'h33);
        pulse(8'h01); chk("R2 masked after reinit", irq_o, 0);
        wr(1'b1, 8'h00);
        ack(d); chk("R3 base 0x80 vector", d, 8'h80);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R3 R8 auto EOI cleared", d, 8'h01);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule